// File: doc/BRIEF.md
# Hex Value ASCII Formatter

This block turns a binary word of up to 32 bits into the ASCII text a serial console shows for it in hexadecimal. A client places the word on `value_i` and raises `start_i` for one cycle while the block is idle. The block then sends the text one byte at a time on a valid/ready output, and pulses `done_o` once the final byte has been taken. The UART, line endings and command parsing all live outside this block.

The text depends on the value. A zero word is sent as the single character `0`. A non-zero word is sent as `0x` followed by its significant hex digits. Zero nibbles above the first non-zero nibble are dropped, so the string is between one and ten characters long. A narrower field is formatted by zero-extending it onto `value_i`, and the printed digits then depend only on the field's value.

Back-pressure rules: a byte is transferred in any cycle where `out_valid_o` and `out_ready_i` are both high. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value. `out_valid_o` never drops until that byte has been accepted. The consumer may hold `out_ready_i` high permanently, and the block then sends one byte per cycle.

Top module: `hex_ascii_fmt`

## Requirements
- R1: Out of reset, `out_valid_o`, `done_o` and `busy_o` are all low.
- R2: A start with `value_i` equal to zero yields exactly one byte, 0x30 ('0'), with no prefix.
- R3: A start with a non-zero value yields 0x30 ('0') and then 0x78 ('x') as its first two bytes.
- R4: After the prefix, the digits run from the most significant non-zero nibble down to nibble 0. Every nibble below the first non-zero nibble is sent, zeros included. The total length is therefore 2 plus the number of significant nibbles, which gives at most 10 bytes.
- R5: A nibble value from 0 to 9 is sent as byte 0x30 to 0x39. A nibble value from 10 to 15 is sent as lowercase byte 0x61 to 0x66.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change in the next cycle.
- R7: A start pulse that arrives while `busy_o` is high is ignored, and the string in progress continues unchanged.
- R8: `done_o` is high for exactly one cycle. That cycle comes right after the cycle in which the last byte is accepted. In that cycle `out_valid_o` and `busy_o` are low.
- R9: The first byte is valid in the cycle right after the start is accepted. With `out_ready_i` held high, each following byte is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a conversion of `value_i` (ignored while busy) |
| value_i | input | VAL_W (32) | Word to format, sampled on an accepted start |
| busy_o | output | 1 | High from the accepted start until the last byte is accepted |
| out_valid_o | output | 1 | Output byte is valid |
| out_data_o | output | 8 | ASCII byte |
| out_ready_i | input | 1 | Consumer accepts the byte this cycle |
| done_o | output | 1 | One-cycle pulse after the last byte has been accepted |

## Verification
The first byte appears one cycle after the edge that samples the start. Each later byte appears one cycle after the edge that accepted the byte before it. `done_o` rises one cycle after the edge that accepts the last byte. The bench drives every input on the falling edge and samples on the next falling edge, so each reading is taken half a period after the rising edge that updated the output and names exactly that cycle. Stall cycles are inserted between accepted bytes so the held value can be compared before the handshake completes. A stray start is applied in the middle of a string, and the rest of that string is still compared byte for byte.

// File: rtl/hexfmt_pkg.sv
package hexfmt_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_LEAD0 = 2'd1,
    FS_LEADX = 2'd2,
    FS_DIGIT = 2'd3
  } fmt_state_e;

  localparam logic [7:0] CH_ZERO   = 8'h30;
  localparam logic [7:0] CH_LOWA   = 8'h61;
  localparam logic [7:0] CH_X      = 8'h78;
  localparam int unsigned NIB_BITS = 4;

endpackage

// File: rtl/hexfmt_msd_scan.sv
module hexfmt_msd_scan #(
  parameter int unsigned NIB_N = 8,
  localparam int unsigned IDX_W = (NIB_N > 1) ? $clog2(NIB_N) : 1
) (
  input  logic [NIB_N*4-1:0] word_i,
  output logic [IDX_W-1:0]   msd_idx_o,
  output logic               nonzero_o
);

  logic [NIB_N-1:0] nib_hot;

  // One flag per nibble: set when that nibble holds a non-zero value
  for (genvar g = 0; g < NIB_N; g++) begin : g_flag
    assign nib_hot[g] = |word_i[g*4 +: 4];
  end

  // The highest set flag wins; an all-zero word points at nibble 0
  always_comb begin
    msd_idx_o = '0;
    for (int i = 0; i < NIB_N; i++) begin
      if (nib_hot[i]) msd_idx_o = IDX_W'(i);
    end
  end

  assign nonzero_o = |nib_hot;

endmodule

// File: rtl/hexfmt_nib_pick.sv
module hexfmt_nib_pick #(
  parameter int unsigned NIB_N = 8,
  localparam int unsigned IDX_W = (NIB_N > 1) ? $clog2(NIB_N) : 1
) (
  input  logic [NIB_N*4-1:0] word_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [3:0]         nib_o
);

  logic [3:0] nibs [NIB_N];

  for (genvar g = 0; g < NIB_N; g++) begin : g_split
    assign nibs[g] = word_i[g*4 +: 4];
  end

  always_comb begin
    nib_o = '0;
    for (int i = 0; i < NIB_N; i++) begin
      if (idx_i == IDX_W'(i)) nib_o = nibs[i];
    end
  end

endmodule

// File: rtl/hexfmt_glyph.sv
module hexfmt_glyph
  import hexfmt_pkg::*;
(
  input  logic [3:0] nib_i,
  output logic [7:0] char_o
);

  // 0-9 go to the decimal digit characters, 10-15 to lowercase letters
  always_comb begin
    if (nib_i < 4'd10) char_o = CH_ZERO + {4'd0, nib_i};
    else               char_o = CH_LOWA + {4'd0, nib_i - 4'd10};
  end

endmodule

// File: rtl/hex_ascii_fmt.sv
module hex_ascii_fmt
  import hexfmt_pkg::*;
#(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  output logic             done_o
);

  localparam int unsigned NIB_N = (VAL_W + NIB_BITS - 1) / NIB_BITS;
  localparam int unsigned PAD_W = NIB_N * NIB_BITS;
  localparam int unsigned IDX_W = (NIB_N > 1) ? $clog2(NIB_N) : 1;

  fmt_state_e       state_q;
  logic [PAD_W-1:0] word_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  logic [PAD_W-1:0] word_in;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_nz;
  logic [3:0]       cur_nib;
  logic [7:0]       digit_char;
  logic             take;
  logic             last_take;

  assign word_in = PAD_W'(value_i);

  hexfmt_msd_scan #(.NIB_N(NIB_N)) u_scan (
    .word_i    (word_in),
    .msd_idx_o (scan_idx),
    .nonzero_o (scan_nz)
  );

  hexfmt_nib_pick #(.NIB_N(NIB_N)) u_pick (
    .word_i (word_q),
    .idx_i  (idx_q),
    .nib_o  (cur_nib)
  );

  hexfmt_glyph u_glyph (
    .nib_i  (cur_nib),
    .char_o (digit_char)
  );

  assign out_valid_o = (state_q != FS_IDLE);
  assign busy_o      = (state_q != FS_IDLE);
  assign done_o      = done_q;
  assign take        = out_valid_o && out_ready_i;
  assign last_take   = take && (state_q == FS_DIGIT) && (idx_q == '0);

  always_comb begin
    unique case (state_q)
      FS_LEAD0: out_data_o = CH_ZERO;
      FS_LEADX: out_data_o = CH_X;
      FS_DIGIT: out_data_o = digit_char;
      default:  out_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      word_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_take;
      unique case (state_q)
        FS_IDLE: begin
          if (start_i) begin
            word_q  <= word_in;
            idx_q   <= scan_idx;
            state_q <= scan_nz ? FS_LEAD0 : FS_DIGIT;
          end
        end
        FS_LEAD0: if (take) state_q <= FS_LEADX;
        FS_LEADX: if (take) state_q <= FS_DIGIT;
        FS_DIGIT: begin
          if (take) begin
            if (idx_q == '0) state_q <= FS_IDLE;
            else             idx_q   <= idx_q - IDX_W'(1);
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hexfmt_chk.sv
module hexfmt_chk #(
  parameter int unsigned VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [VAL_W-1:0] value_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_ready_i,
  input logic             done_o
);

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!out_valid_o && !busy_o));

  // R9
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> out_valid_o);

  // R5
  legal_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_data_o >= 8'h30 && out_data_o <= 8'h39) ||
                     (out_data_o >= 8'h61 && out_data_o <= 8'h66) ||
                     out_data_o == 8'h78));

endmodule

bind hex_ascii_fmt hexfmt_chk #(.VAL_W(VAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .value_i     (value_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .done_o      (done_o)
);

// File: tb/hex_ascii_fmt_test.sv
module hex_ascii_fmt_test;

  localparam int NV = 8;
  localparam logic [31:0] VALS [NV] = '{
    32'h0000_0000, 32'h0000_0001, 32'h0000_000A, 32'hDEAD_BEEF,
    32'h0010_0200, 32'h8000_0000, 32'h0000_F00F, 32'h0000_0010};
  localparam int LENS [NV] = '{1, 3, 3, 10, 8, 10, 6, 4};
  localparam logic [79:0] STRS [NV] = '{
    80'("0"), 80'("0x1"), 80'("0xa"), 80'("0xdeadbeef"),
    80'("0x100200"), 80'("0x80000000"), 80'("0xf00f"), 80'("0x10")};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] value_i = '0;
  logic        busy_o, out_valid_o, out_ready_i, done_o;
  logic [7:0]  out_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hex_ascii_fmt uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .busy_o(busy_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .done_o(done_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Run one string; stall inserts a not-ready cycle before each byte.
  // stray fires a start with a zero value in the middle of the string.
  task automatic run_str(input logic [31:0] v, input int len,
                         input logic [79:0] s, input bit stall, input bit stray);
    @(negedge clk);
    value_i = v; start_i = 1'b1; out_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(out_valid_o, "R9 first byte valid", 32'(out_valid_o), 1);
    for (int k = 0; k < len; k++) begin
      logic [7:0] exp_c;
      exp_c = s[(len-1-k)*8 +: 8];
      if (stall) begin
        logic [7:0] held;
        held = out_data_o;
        @(negedge clk);
        chk(out_valid_o && out_data_o == held, "R6 held while stalled",
            32'(out_data_o), 32'(held));
      end
      if (k == 0 && v == 0)
        chk(out_data_o == 8'h30, "R2 zero prints bare 0", 32'(out_data_o), 32'h30);
      else if (k < 2)
        chk(out_data_o == exp_c, "R3 prefix byte", 32'(out_data_o), 32'(exp_c));
      else
        chk(out_data_o == exp_c, "R4/R5 digit byte", 32'(out_data_o), 32'(exp_c));
      chk(out_valid_o && !done_o, "R9 byte valid, no done", 32'(out_valid_o), 1);
      out_ready_i = 1'b1;
      if (stray && k == 1) begin
        start_i = 1'b1; value_i = 32'h0;
      end
      @(negedge clk);
      start_i = 1'b0;
      out_ready_i = stall ? 1'b0 : 1'b1;
    end
    out_ready_i = 1'b0;
    chk(done_o && !out_valid_o && !busy_o, "R8 done after last byte",
        32'({done_o, out_valid_o, busy_o}), 32'b100);
    @(negedge clk);
    chk(!done_o && !out_valid_o, "R8 done lasts one cycle / R4 length",
        32'({done_o, out_valid_o}), 0);
  endtask

  initial begin
    out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid_o && !done_o && !busy_o, "R1 reset state",
        32'({out_valid_o, done_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !busy_o, "R1 idle after reset", 32'({out_valid_o, busy_o}), 0);

    for (int i = 0; i < NV; i++) run_str(VALS[i], LENS[i], STRS[i], 1'b0, 1'b0);
    // Stalled consumer on a full-length string
    run_str(32'hDEAD_BEEF, 10, 80'("0xdeadbeef"), 1'b1, 1'b0);
    // R7: stray start mid-string is ignored
    run_str(32'h0000_1234, 6, 80'("0x1234"), 1'b0, 1'b1);
    // R5: every letter digit
    run_str(32'hABCD_EF09, 10, 80'("0xabcdef09"), 1'b1, 1'b0);
    // R2 zero under stall
    run_str(32'h0, 1, 80'("0"), 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule